// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and a calendar in eight packed BCD bytes. It counts hundredths of seconds, seconds, minutes, hours, day of the week, day of the month, month and two-digit year. It advances on a single-cycle enable that the surrounding logic pulses at 100 Hz. All carries ripple through the whole chain on the same clock edge. The hours byte holds its own format select, so each load picks 24-hour counting or 12-hour counting with a PM flag. The day-of-week byte also carries two control bits. One stops the clock. The other tells a neighbouring transfer block whether to honour an external abort input, and is only stored and exported here.

A host interface writes all eight bytes at once through a parallel load port and reads the current time from a registered snapshot bus. Byte k of either bus sits at bits [8k+7:8k]. Byte 0 holds hundredths, then seconds, minutes, hours, day, date and month, with byte 7 holding the year. Bits that carry no meaning always read as zero. Out of reset the core holds 00:00:00.00 (24-hour), day 1, date 01, month 01, year 00, and it is stopped.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the snapshot reads 0x00 for hundredths, seconds, minutes, hours and year, 0x21 for the day byte (day 1, stop bit set), and 0x01 for date and month. osc_off reads 1 and rst_ignore reads 0.
- R2: When the stop bit (day byte bit 5) is 0 and no load is requested, each cycle with tick_en high advances hundredths by one in BCD. Hundredths wrap 99→00 into seconds, seconds wrap 59→00 into minutes, and minutes wrap 59→00 into hours, all on the same edge.
- R3: While the stop bit is 1, tick_en has no effect on any byte.
- R4: With hours bit 7 at 0 (24-hour mode), hours count 00..23 in BCD, with bit 5 as the tens-of-twenty bit and bit 4 as tens-of-ten. The step from 23 to 00 advances the day of week and the date.
- R5: With hours bit 7 at 1 (12-hour mode), bits 4:0 hold 1..12 in BCD and bit 5 is the PM flag. The sequence runs 12, 01, …, 11, 12. The step 11→12 inverts the PM flag, and only the step from 11 PM to 12 AM advances the day of week and the date.
- R6: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: February ends on 29 when the year is a multiple of four (00 included) and on 28 otherwise.
- R8: The day of week (day byte bits 2:0) counts 1..7 and wraps 7→1 whenever the date advances.
- R9: With ld_en high, all eight bytes take the load values on that one edge, and a tick on the same edge is discarded.
- R10: Reserved bits always read 0, whatever is loaded into them. These are seconds bit 7, minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7 and 6, and month bits 7 to 5.
- R11: osc_off equals day byte bit 5 and rst_ignore equals day byte bit 4. Both change only through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 100 Hz advance enable |
| ld_en | input | 1 | Load all eight bytes from ld_data |
| ld_data | input | 64 | Load values, byte k at bits [8k+7:8k] |
| snap_q | output | 64 | Registered snapshot of all eight bytes |
| osc_off | output | 1 | Stop bit from the day byte |
| rst_ignore | output | 1 | Abort-ignore bit from the day byte, for the transfer logic |

## Verification
Every result is due exactly one edge after its stimulus. A tick or a load sampled at rising edge N shows on snap_q and on the control outputs right after edge N, with no extra pipeline stage, even for a carry that runs from hundredths up to the year. The bench drives tick_en and ld_en at a falling edge and drops them at the next falling edge. It compares the outputs at that same falling edge, which falls half a cycle after the single edge that acted. Each scenario loads a time just short of the boundary it probes, so one tick decides the result.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int BUS_W    = REG_W * NUM_REGS;

  // byte positions on the load and snapshot buses
  localparam int IDX_HUND = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HOUR = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_DATE = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YEAR = 7;

  localparam int DAY_STOP_BIT  = 5;
  localparam int DAY_IGNRE_BIT = 4;

  localparam logic [REG_W-1:0] DAY_RST  = 8'h21;
  localparam logic [REG_W-1:0] ONE_BCD  = 8'h01;

  // writable bits of each byte; the rest always read as zero
  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h7F;
      IDX_HOUR:         return 8'hBF;
      IDX_DAY:          return 8'h37;
      IDX_DATE:         return 8'h3F;
      IDX_MON:          return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] bus_mask();
    logic [BUS_W-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) m[i*REG_W +: REG_W] = reg_mask(i);
    return m;
  endfunction

  // last value before wrap for the plain modulo counters
  function automatic logic [REG_W-1:0] wrap_of(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h59;
      default:          return 8'h99;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 mod 4 == 2, so value mod 4 = (2*tens[0] + units) mod 4
  function automatic logic is_leap(input logic [REG_W-1:0] yr);
    logic [1:0] r;
    r = yr[1:0] + {yr[4], 1'b0};
    return (r == 2'd0);
  endfunction

  function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr #(
  parameter int               W       = rtc_pkg::REG_W,
  parameter logic [W-1:0]     WRAP    = 8'h99,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         at_wrap
);
  assign at_wrap = (q == WRAP);

  always_ff @(posedge clk) begin
    if (rst)       q <= RST_VAL;
    else if (load) q <= load_val;
    else if (inc)  q <= at_wrap ? '0 : rtc_pkg::bcd_inc(q);
  end
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit #(
  parameter int W = rtc_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         day_step
);
  logic [W-1:0] nxt;
  logic         wrap_day;
  logic         mode12;

  assign mode12 = q[7];

  always_comb begin
    nxt      = q;
    wrap_day = 1'b0;
    if (mode12) begin
      if (q[4:0] == 5'h12) begin
        nxt = {q[7], 1'b0, q[5], 5'h01};
      end else if (q[4:0] == 5'h11) begin
        nxt      = {q[7], 1'b0, ~q[5], 5'h12};
        wrap_day = q[5];
      end else if (q[3:0] == 4'd9) begin
        nxt = {q[7], 1'b0, q[5], 5'h10};
      end else begin
        nxt = {q[7], 1'b0, q[5:4], q[3:0] + 4'd1};
      end
    end else begin
      if (q[5:0] == 6'h23) begin
        nxt      = {q[7], 7'h00};
        wrap_day = 1'b1;
      end else if (q[3:0] == 4'd9) begin
        nxt = {q[7], 1'b0, q[5:4] + 2'd1, 4'd0};
      end else begin
        nxt = {q[7], 1'b0, q[5:4], q[3:0] + 4'd1};
      end
    end
  end

  assign day_step = inc & wrap_day;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= nxt;
  end
endmodule

// File: rtl/rtc_cal_unit.sv
module rtc_cal_unit #(
  parameter int W = rtc_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] ld_day,
  input  logic [W-1:0] ld_date,
  input  logic [W-1:0] ld_mon,
  input  logic [W-1:0] year_q,
  output logic [W-1:0] day_q,
  output logic [W-1:0] date_q,
  output logic [W-1:0] mon_q,
  output logic         year_step
);
  import rtc_pkg::*;

  logic [W-1:0] last_date;
  logic         month_end;
  logic         year_end;
  logic [2:0]   dow_nxt;

  assign last_date = month_last(mon_q, is_leap(year_q));
  assign month_end = (date_q == last_date);
  assign year_end  = month_end & (mon_q == 8'h12);
  assign year_step = inc & year_end;
  assign dow_nxt   = (day_q[2:0] == 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      day_q  <= DAY_RST;
      date_q <= ONE_BCD;
      mon_q  <= ONE_BCD;
    end else if (load) begin
      day_q  <= ld_day;
      date_q <= ld_date;
      mon_q  <= ld_mon;
    end else if (inc) begin
      day_q <= {day_q[7:3], dow_nxt};
      if (month_end) begin
        date_q <= ONE_BCD;
        mon_q  <= (mon_q == 8'h12) ? ONE_BCD : bcd_inc(mon_q);
      end else begin
        date_q <= bcd_inc(date_q);
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             ld_en,
  input  logic [BUS_W-1:0] ld_data,
  output logic [BUS_W-1:0] snap_q,
  output logic             osc_off,
  output logic             rst_ignore
);
  localparam int N_FAST = 3; // hundredths, seconds, minutes

  logic [REG_W-1:0] ld_b  [NUM_REGS];
  logic [REG_W-1:0] reg_q [NUM_REGS];
  logic [N_FAST:0]  step;
  logic             hour_carry;
  logic             year_carry;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_ld
      assign ld_b[gi] = ld_data[gi*REG_W +: REG_W] & reg_mask(gi);
      assign snap_q[gi*REG_W +: REG_W] = reg_q[gi];
    end
  endgenerate

  assign step[0] = tick_en & ~ld_en & ~reg_q[IDX_DAY][DAY_STOP_BIT];

  generate
    for (gi = 0; gi < N_FAST; gi++) begin : g_fast
      logic wrap_i;
      rtc_bcd_ctr #(.W(REG_W), .WRAP(wrap_of(gi))) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .inc      (step[gi]),
        .load     (ld_en),
        .load_val (ld_b[gi]),
        .q        (reg_q[gi]),
        .at_wrap  (wrap_i)
      );
      assign step[gi+1] = step[gi] & wrap_i;
    end
  endgenerate

  rtc_hour_unit #(.W(REG_W)) u_hour (
    .clk      (clk),
    .rst      (rst),
    .inc      (step[N_FAST]),
    .load     (ld_en),
    .load_val (ld_b[IDX_HOUR]),
    .q        (reg_q[IDX_HOUR]),
    .day_step (hour_carry)
  );

  rtc_cal_unit #(.W(REG_W)) u_cal (
    .clk       (clk),
    .rst       (rst),
    .inc       (hour_carry),
    .load      (ld_en),
    .ld_day    (ld_b[IDX_DAY]),
    .ld_date   (ld_b[IDX_DATE]),
    .ld_mon    (ld_b[IDX_MON]),
    .year_q    (reg_q[IDX_YEAR]),
    .day_q     (reg_q[IDX_DAY]),
    .date_q    (reg_q[IDX_DATE]),
    .mon_q     (reg_q[IDX_MON]),
    .year_step (year_carry)
  );

  logic year_wrap_unused;
  rtc_bcd_ctr #(.W(REG_W), .WRAP(8'h99)) u_year (
    .clk      (clk),
    .rst      (rst),
    .inc      (year_carry),
    .load     (ld_en),
    .load_val (ld_b[IDX_YEAR]),
    .q        (reg_q[IDX_YEAR]),
    .at_wrap  (year_wrap_unused)
  );

  assign osc_off    = reg_q[IDX_DAY][DAY_STOP_BIT];
  assign rst_ignore = reg_q[IDX_DAY][DAY_IGNRE_BIT];
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
  import rtc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             ld_en,
  input logic [BUS_W-1:0] ld_data,
  input logic [BUS_W-1:0] snap_q,
  input logic             osc_off
);
  localparam logic [BUS_W-1:0] MASK = bus_mask();

  // R3: stopped clock ignores ticks
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (osc_off && !ld_en) |=> $stable(snap_q));

  // R2: nothing moves without a tick or a load
  a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ld_en) |=> $stable(snap_q));

  // R9: load lands whole on one edge
  a_r9_load_atomic: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (snap_q == ($past(ld_data) & MASK)));

  // R10: reserved bits stay zero
  a_r10_zero_bits: assert property (@(posedge clk) disable iff (rst)
    ((snap_q & ~MASK) == '0));

  // R11: stop bit changes only through a load
  a_r11_stop_by_load: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(osc_off));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .ld_en   (ld_en),
  .ld_data (ld_data),
  .snap_q  (snap_q),
  .osc_off (osc_off)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        ld_en = 1'b0;
  logic [63:0] ld_data = '0;
  logic [63:0] snap_q;
  logic        osc_off;
  logic        rst_ignore;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_core u_bcd_rtc_core (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(ld_en),
    .ld_data(ld_data), .snap_q(snap_q), .osc_off(osc_off), .rst_ignore(rst_ignore)
  );

  function automatic logic [63:0] pk(input logic [7:0] h, s, m, hr, dy, dt, mo, yr);
    return {yr, mo, dt, dy, hr, m, s, h};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic load(input logic [63:0] v, input logic with_tick);
    @(negedge clk);
    ld_en = 1'b1; ld_data = v; tick_en = with_tick;
    @(negedge clk);
    ld_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic step_case(input string req, input logic [63:0] v, input logic [63:0] exp);
    load(v, 1'b0);
    tick();
    chk(req, snap_q, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset bytes", snap_q, pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h21, 8'h01, 8'h01, 8'h00));
    chk("R1 reset ctrl", {62'd0, osc_off, rst_ignore}, 64'd2);
  endtask

  task automatic t_stopped();
    load(pk(8'h05, 8'h10, 8'h20, 8'h03, 8'h21, 8'h02, 8'h03, 8'h04), 1'b0);
    repeat (3) tick();
    chk("R3 stopped", snap_q, pk(8'h05, 8'h10, 8'h20, 8'h03, 8'h21, 8'h02, 8'h03, 8'h04));
  endtask

  task automatic t_fast();
    step_case("R2 units carry", pk(8'h09, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00),
              pk(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    step_case("R2 sec min carry", pk(8'h99, 8'h59, 8'h05, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00),
              pk(8'h00, 8'h00, 8'h06, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
  endtask

  task automatic t_hours24();
    step_case("R4 19 to 20", pk(8'h99, 8'h59, 8'h59, 8'h19, 8'h02, 8'h10, 8'h05, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'h20, 8'h02, 8'h10, 8'h05, 8'h21));
    step_case("R4 23 to 00", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h16, 8'h06, 8'h21));
  endtask

  task automatic t_hours12();
    step_case("R5 11AM to 12PM", pk(8'h99, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h05, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'hB2, 8'h02, 8'h10, 8'h05, 8'h21));
    step_case("R5 11PM to 12AM", pk(8'h99, 8'h59, 8'h59, 8'hB1, 8'h02, 8'h10, 8'h05, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'h92, 8'h03, 8'h11, 8'h05, 8'h21));
    step_case("R5 12 to 01", pk(8'h99, 8'h59, 8'h59, 8'hB2, 8'h02, 8'h10, 8'h05, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'hA1, 8'h02, 8'h10, 8'h05, 8'h21));
    step_case("R5 09 to 10", pk(8'h99, 8'h59, 8'h59, 8'h89, 8'h02, 8'h10, 8'h05, 8'h21),
              pk(8'h00, 8'h00, 8'h00, 8'h90, 8'h02, 8'h10, 8'h05, 8'h21));
  endtask

  task automatic t_months();
    step_case("R6 R8 year wrap", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    step_case("R6 april end", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h33),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h33));
    step_case("R6 jan 30 stays", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h01, 8'h33),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h06, 8'h31, 8'h01, 8'h33));
  endtask

  task automatic t_leap();
    step_case("R7 leap 24 feb28", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h24));
    step_case("R7 leap 24 feb29", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h24));
    step_case("R7 plain 23", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23));
    step_case("R7 leap 00", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00));
    step_case("R7 plain 10", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h10));
    step_case("R7 leap 12", pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12),
              pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h12));
  endtask

  task automatic t_load_tick();
    load(pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99), 1'b1);
    chk("R9 tick dropped", snap_q, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99));
    @(negedge clk);
    chk("R9 holds", snap_q, pk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99));
  endtask

  task automatic t_zero_bits();
    load(pk(8'h42, 8'hC5, 8'hB0, 8'h52, 8'hCB, 8'hD7, 8'hE9, 8'h55), 1'b0);
    chk("R10 masked", snap_q, pk(8'h42, 8'h45, 8'h30, 8'h12, 8'h03, 8'h17, 8'h09, 8'h55));
  endtask

  task automatic t_ctrl();
    load(pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h14, 8'h01, 8'h01, 8'h00), 1'b0);
    chk("R11 ignore set", {62'd0, osc_off, rst_ignore}, 64'd1);
    tick();
    chk("R11 ticks keep ctrl", {62'd0, osc_off, rst_ignore}, 64'd1);
    load(pk(8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h01, 8'h01, 8'h00), 1'b0);
    chk("R11 stop set", {62'd0, osc_off, rst_ignore}, 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_fast();
    t_hours24();
    t_hours12();
    t_months();
    t_leap();
    t_load_tick();
    t_zero_bits();
    t_ctrl();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule